// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block is a 22-bit periodic timer that sits on a small processor bus with 8-bit data. Software loads a reload value through three write-only byte registers and then starts the counter. The counter counts upward from zero on an effective 33 MHz tick. Each time it reaches the reload value it returns to zero, so one period lasts exactly reload-value ticks. A level interrupt marks each completed period.

The count is read back as four bytes. A read of the lowest count byte takes a snapshot of the whole count, and the other three bytes then return slices of that snapshot. This lets software assemble a consistent 22-bit value from byte reads while the counter keeps running. Each of the three lower readback bytes carries a 6-bit slice of the count, split across the byte as described in R3.

The interrupt is acknowledged by writing the interrupt-enable bit to 0 and then back to 1. When the board's input clock runs at 66 MHz, a select input halves the tick rate, so the count rate stays at 33 MHz.

Top module: `interval_timer`

## Requirements
- R1: After reset the control register reads 0x00, the count reads 0, the reload value is 0 and `irq` is low.
- R2: Writes to address 0, 1 and 2 load reload bits 7:0, 15:8 and 21:16. For address 2 only write bits 5:0 are used, and bits 7:6 are ignored.
- R3: Readback uses address 0, 1 and 2 for count slices 5:0, 11:6 and 17:12. In each of these bytes, slice bits 4:0 appear in byte bits 4:0 and slice bit 5 appears in byte bit 6. Address 3 returns count bits 21:18 in byte bits 3:0. All other readback bits are 0.
- R4: A read of address 0 returns the live count and captures the full count into a snapshot. Reads of address 1 to 3 return the snapshot, not the live count.
- R5: The control register at address 4 uses bit 0 for run and bit 1 for interrupt enable. It reads back exactly these stored bits, with bits 7:2 read as 0, and reads of address 5 to 7 return 0. While run is 0 the count holds its value.
- R6: A control write that changes run from 0 to 1 clears the count to 0 and starts a fresh period.
- R7: While running, the count steps 0, 1, ... reload-1 and then wraps to 0, so a period is reload ticks long. A reload of 0 or 1 wraps on every tick.
- R8: `irq` is a level. It is set by a wrap while interrupt enable is 1 and stays high until a control write clears interrupt enable. A wrap while interrupt enable is 0 leaves `irq` low, even after interrupt enable is set again.
- R9: With `clk66_sel` low the count ticks on every clock. With `clk66_sel` high it ticks on every second clock, and the first tick after a start falls on the second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| clk66_sel | input | 1 | High when the clock must be divided by two for the tick |
| irq | output | 1 | Level period interrupt |

## Verification
The block has a fixed 22-bit width and no overridable parameters, so the bench builds it as it stands. It runs the block with `clk66_sel` both low and high.

A frozen count of 4005 sets slice bit 5 in both of the two lowest readback groups, which exercises the displaced bit. Count bits 21:18 cannot be reached within the run length, so the top readback byte is only checked at zero.

Reload values of 0, 3, 5 and full scale cover these cases:
- a wrap on every tick,
- divided and undivided periods,
- acknowledgement ordering,
- the ignored top bits of the third reload byte.

// File: rtl/interval_timer.sv
module interval_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       clk66_sel,
  output logic       irq
);
  localparam int CW = 22;

  logic [CW-1:0] count_q, reload_q, snap_q;
  logic          run_q, ie_q, pend_q, phase_q;

  logic wr_en, rd_en, ctrl_wr, run_n, ie_n, start, active, adv, hit;
  logic [CW:0] nxt;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign ctrl_wr = wr_en && bus_addr == 3'd4;
  assign run_n   = ctrl_wr ? bus_wdata[0] : run_q;
  assign ie_n    = ctrl_wr ? bus_wdata[1] : ie_q;
  assign start   = run_n & ~run_q;
  assign active  = run_n & run_q;
  assign adv     = active & (~clk66_sel | phase_q);
  assign nxt     = {1'b0, count_q} + 1'b1;
  assign hit     = nxt >= {1'b0, reload_q};
  assign irq     = pend_q;

  function automatic logic [7:0] pack6(input logic [5:0] g);
    return {1'b0, g[5], 1'b0, g[4:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      snap_q   <= '0;
      run_q    <= 1'b0;
      ie_q     <= 1'b0;
      pend_q   <= 1'b0;
      phase_q  <= 1'b0;
    end else begin
      run_q <= run_n;
      ie_q  <= ie_n;
      if (start) begin
        count_q <= '0;
        phase_q <= 1'b0;
      end else if (active) begin
        phase_q <= ~phase_q;
        if (adv) count_q <= hit ? '0 : nxt[CW-1:0];
      end
      if (!ie_n) pend_q <= 1'b0;
      else if (adv && hit) pend_q <= 1'b1;
      if (wr_en) begin
        case (bus_addr)
          3'd0: reload_q[7:0]   <= bus_wdata;
          3'd1: reload_q[15:8]  <= bus_wdata;
          3'd2: reload_q[21:16] <= bus_wdata[5:0];
          default: ;
        endcase
      end
      if (rd_en && bus_addr == 3'd0) snap_q <= count_q;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = pack6(count_q[5:0]);
      3'd1:    bus_rdata = pack6(snap_q[11:6]);
      3'd2:    bus_rdata = pack6(snap_q[17:12]);
      3'd3:    bus_rdata = {4'b0, snap_q[21:18]};
      3'd4:    bus_rdata = {6'b0, ie_q, run_q};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

module interval_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [21:0] count,
  input logic        run,
  input logic        ie,
  input logic        irq,
  input logic [7:0]  rdata
);
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> count == $past(count));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> count == 22'd0);

  a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie);

  a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq) && $past(ie) && ie) |-> irq);

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |->
      (count == $past(count) || count == $past(count) + 22'd1 || count == 22'd0));

  a_r3_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7] == 1'b0);
endmodule

bind interval_timer interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .count(count_q), .run(run_q),
  .ie(ie_q), .irq(irq), .rdata(bus_rdata)
);

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, clk66_sel = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  interval_timer u_interval_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk66_sel(clk66_sel), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pk(input logic [5:0] g);
    return {1'b0, g[5], 1'b0, g[4:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(irq == 0, "R1 irq", irq, 0);
    rd(3'd4, d); check(d == 8'h00, "R1 ctrl", d, 0);
    rd(3'd0, d); check(d == 8'h00, "R1 count", d, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(3'd4, 8'hFF);
    rd(3'd4, d); check(d == 8'h03, "R5 ctrl readback", d, 8'h03);
    check(irq == 1, "R7 reload zero wraps each tick", irq, 1);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check(d == 8'h00, "R5 ctrl cleared", d, 0);
    check(irq == 0, "R8 ack clears", irq, 0);
    wr(3'd4, 8'h02);
    rd(3'd4, d); check(d == 8'h02, "R5 ie only", d, 8'h02);
    rd(3'd5, d); check(d == 8'h00, "R5 unused addr", d, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_snapshot();
    logic [7:0] d;
    logic [21:0] v = 22'd4005;
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd4, 8'h01);
    repeat (4005) @(negedge clk);
    wr(3'd4, 8'h00);
    rd(3'd0, d); check(d == pk(v[5:0]), "R3 R5 byte0 frozen", d, pk(v[5:0]));
    repeat (5) @(negedge clk);
    rd(3'd0, d); check(d == pk(v[5:0]), "R5 freeze holds", d, pk(v[5:0]));
    wr(3'd4, 8'h01);
    rd(3'd1, d); check(d == pk(v[11:6]), "R4 R3 byte1 snapshot", d, pk(v[11:6]));
    rd(3'd2, d); check(d == pk(v[17:12]), "R4 byte2 snapshot", d, pk(v[17:12]));
    rd(3'd3, d); check(d == 8'h00, "R3 byte3", d, 0);
    wr(3'd4, 8'h00);
    wr(3'd4, 8'h01); wr(3'd4, 8'h00);
    rd(3'd0, d); check(d == 8'h00, "R6 restart from zero", d, 0);
  endtask

  task automatic t_irq();
    wr(3'd0, 8'h05); wr(3'd1, 8'h00); wr(3'd2, 8'hC0);
    wr(3'd4, 8'h03);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); check(irq == 0, "R7 R2 before wrap", irq, 0);
    end
    @(negedge clk); check(irq == 1, "R7 R2 wrap at reload", irq, 1);
    repeat (7) @(negedge clk);
    check(irq == 1, "R8 level held", irq, 1);
    wr(3'd4, 8'h01); check(irq == 0, "R8 ack low", irq, 0);
    wr(3'd4, 8'h03); check(irq == 0, "R8 re-enable low", irq, 0);
    repeat (6) @(negedge clk);
    check(irq == 1, "R8 next period", irq, 1);
    wr(3'd4, 8'h01);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); check(irq == 0, "R8 ie clear no pend", irq, 0);
    end
    wr(3'd4, 8'h00); wr(3'd4, 8'h02);
    check(irq == 0, "R8 no stale pend", irq, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_div();
    logic [7:0] d;
    clk66_sel = 1;
    wr(3'd0, 8'h03); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    wr(3'd4, 8'h03);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk); check(irq == 0, "R9 divided before wrap", irq, 0);
    end
    @(negedge clk); check(irq == 1, "R9 divided wrap", irq, 1);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'hFF);
    wr(3'd4, 8'h01);
    repeat (10) @(negedge clk);
    wr(3'd4, 8'h00);
    rd(3'd0, d); check(d == 8'h05, "R9 half rate count", d, 8'h05);
    clk66_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_snapshot();
    t_irq();
    t_div();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule